// File: doc/BRIEF.md
# Polled EEPROM Write Sequencer

This block sits on the host side of a parallel byte-wide EEPROM. It loads either one byte or a run of bytes into one page of the memory. It drives the memory's select, read-enable and write-enable strobes, and it drives the address and the core side of a tri-state data pad. It does not wait out the worst-case programming time. Once the last byte is loaded, the sequencer keeps reading back the last written location. It compares the top data bit of each read with the top bit it wrote. While the memory is still programming, that bit comes back inverted. When the two bits agree, the write is finished.

A write starts with one command beat, which gives the start address and the byte count. The bytes then follow on a separate valid/ready data stream, one byte for each handshake.

- Command back-pressure: `cmd_ready` is high only while the sequencer is idle. Nothing is taken from `cmd_*` while it is low.
- Data back-pressure: `dat_ready` is high only while the sequencer waits for the next byte of the current command. A producer may hold `dat_valid` low for as long as it likes. However, the memory ends page loading if the gap between two byte loads grows too long, so bytes should arrive promptly.

Strobe widths, setup and hold, the read access time and the timeout are parameters counted in clock cycles. The pause between polls is an input, so software can free the bus for other work between reads.

Top module: `eeprom_poll_writer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises: `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `dq_oe`, `dat_ready`, `done` and `timeout_err` are 0, and `cmd_ready` is 1.
- R2: A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` then stays low until the operation ends. Each `dat_valid`/`dat_ready` handshake loads exactly one byte. `dat_valid` has no effect while no command is active: no strobe moves and `dat_ready` stays 0.
- R3: For each byte, `mem_cs_n` is low with `mem_oe_n` high for exactly SETUP_CYC cycles before `mem_we_n` falls. `mem_we_n` is then low for exactly PULSE_CYC cycles, with the address held stable. Select and data drive remain for exactly HOLD_CYC cycles after `mem_we_n` rises. `dq_out` carries the byte for the whole time.
- R4: `dq_oe` is 1 only while `mem_cs_n` is 0 and `mem_oe_n` is 1. Otherwise the pad is released.
- R5: Byte k of a command (k from 0) is written at an address whose upper ADDR_W-PAGE_BITS bits equal those of `cmd_addr` and whose low PAGE_BITS bits are (low bits of `cmd_addr` + k) modulo 2^PAGE_BITS.
- R6: `cmd_count` holds the number of bytes minus one, so 0 writes one byte and all ones writes a full page of 2^PAGE_BITS bytes.
- R7: After the last byte, every poll read drives the last written address with `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `dq_oe`=0. Each read is preceded by at least max(`poll_gap`,1) cycles with `mem_cs_n` high.
- R8: `done` pulses high for one cycle, with `cmd_ready` high in that cycle, as soon as a poll read returns a value whose bit DATA_W-1 equals bit DATA_W-1 of the last byte written. It never pulses while that bit reads back inverted.
- R9: If no matching poll occurs within TIMEOUT_CYC cycles after the last byte's hold ends, `timeout_err` pulses for one cycle instead of `done`, and the sequencer returns to idle ready for a new command.
- R10: `done` and `timeout_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_addr | input | ADDR_W | Address of the first byte |
| cmd_count | input | PAGE_BITS | Byte count minus one |
| dat_valid | input | 1 | Data byte valid |
| dat_ready | output | 1 | Sequencer waiting for a byte |
| dat_byte | input | DATA_W | Byte to write |
| poll_gap | input | GAP_W | Idle cycles before each poll read |
| done | output | 1 | One-cycle pulse: programming finished |
| timeout_err | output | 1 | One-cycle pulse: polling window expired |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| dq_out | output | DATA_W | Data to the pad |
| dq_oe | output | 1 | Pad output enable |
| dq_in | input | DATA_W | Data from the pad |

## Verification
A wrong phase count or a skipped state appears at once on the strobe pins. A write pulse, setup run or hold run of the wrong length is caught within the same byte. A bad address step is caught at the rising edge of that byte's write enable. A poll comparator that uses the wrong polarity or the wrong bit shows up in one of two ways:

- `done` arrives while the memory still returns the inverted bit, which is caught within one read access, or
- `done` never arrives and the timeout takes its place.

A timeout counter that starts at the wrong time or never expires shows up as a wrong elapsed cycle count on `timeout_err`.

// File: rtl/ewp_pkg.sv
package ewp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_GAP,
    ST_READ
  } ewp_state_t;
endpackage

// File: rtl/ewp_cycle_timer.sv
module ewp_cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ewp_page_addr.sv
module ewp_page_addr #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] stepped;

  generate
    if (PAGE_BITS >= ADDR_W) begin : g_flat
      assign stepped = cur + ADDR_W'(1);
    end else begin : g_paged
      assign stepped = {cur[ADDR_W-1:PAGE_BITS],
                        cur[PAGE_BITS-1:0] + PAGE_BITS'(1)};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     cur <= '0;
    else if (load)  cur <= base;
    else if (step)  cur <= stepped;
  end

  assign addr = cur;
endmodule

// File: rtl/ewp_timeout.sv
module ewp_timeout #(
  parameter int LIMIT = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear)             cnt <= '0;
    else if (run && !expired)   cnt <= cnt + W'(1);
  end

  assign expired = (cnt >= LIM_V);
endmodule

// File: rtl/eeprom_poll_writer.sv
module eeprom_poll_writer
  import ewp_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int PAGE_BITS   = 6,
  parameter int GAP_W       = 16,
  parameter int SETUP_CYC   = 4,
  parameter int PULSE_CYC   = 32,
  parameter int HOLD_CYC    = 4,
  parameter int READ_CYC    = 32,
  parameter int TIMEOUT_CYC = 2000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [PAGE_BITS-1:0] cmd_count,
  input  logic                 dat_valid,
  output logic                 dat_ready,
  input  logic [DATA_W-1:0]    dat_byte,
  input  logic [GAP_W-1:0]     poll_gap,
  output logic                 done,
  output logic                 timeout_err,
  output logic                 mem_cs_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    dq_out,
  output logic                 dq_oe,
  input  logic [DATA_W-1:0]    dq_in
);
  localparam logic [GAP_W-1:0] SETUP_LD = GAP_W'(SETUP_CYC - 1);
  localparam logic [GAP_W-1:0] PULSE_LD = GAP_W'(PULSE_CYC - 1);
  localparam logic [GAP_W-1:0] HOLD_LD  = GAP_W'(HOLD_CYC - 1);
  localparam logic [GAP_W-1:0] READ_LD  = GAP_W'(READ_CYC - 1);
  localparam int               MSB      = DATA_W - 1;

  ewp_state_t state, nxt;

  logic [PAGE_BITS-1:0] remaining;
  logic [DATA_W-1:0]    wdata;
  logic [ADDR_W-1:0]    last_addr;
  logic                 last_msb;
  logic                 done_q, err_q;

  logic                 t_load, t_exp;
  logic [GAP_W-1:0]     t_val;
  logic                 a_load, a_step;
  logic [ADDR_W-1:0]    cur_addr;
  logic                 to_clear, to_run, to_exp;
  logic                 set_done, set_err, cap_data, cnt_load, save_last;
  logic [GAP_W-1:0]     gap_ld;
  logic                 unused_low;

  assign unused_low = ^dq_in[MSB-1:0];
  assign gap_ld = (poll_gap == '0) ? '0 : poll_gap - GAP_W'(1);

  ewp_cycle_timer #(.W(GAP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  ewp_page_addr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(a_load), .base(cmd_addr),
    .step(a_step), .addr(cur_addr)
  );

  ewp_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear(to_clear), .run(to_run), .expired(to_exp)
  );

  assign to_run = (state == ST_GAP) || (state == ST_READ);

  always_comb begin
    nxt       = state;
    t_load    = 1'b0;
    t_val     = '0;
    a_load    = 1'b0;
    a_step    = 1'b0;
    to_clear  = 1'b0;
    set_done  = 1'b0;
    set_err   = 1'b0;
    cap_data  = 1'b0;
    cnt_load  = 1'b0;
    save_last = 1'b0;
    case (state)
      ST_IDLE: if (cmd_valid) begin
        nxt      = ST_LOAD;
        a_load   = 1'b1;
        cnt_load = 1'b1;
      end
      ST_LOAD: if (dat_valid) begin
        nxt      = ST_SETUP;
        cap_data = 1'b1;
        t_load   = 1'b1;
        t_val    = SETUP_LD;
      end
      ST_SETUP: if (t_exp) begin
        nxt    = ST_STROBE;
        t_load = 1'b1;
        t_val  = PULSE_LD;
      end
      ST_STROBE: if (t_exp) begin
        nxt    = ST_HOLD;
        t_load = 1'b1;
        t_val  = HOLD_LD;
      end
      ST_HOLD: if (t_exp) begin
        if (remaining == '0) begin
          nxt       = ST_GAP;
          save_last = 1'b1;
          to_clear  = 1'b1;
          t_load    = 1'b1;
          t_val     = gap_ld;
        end else begin
          nxt    = ST_LOAD;
          a_step = 1'b1;
        end
      end
      ST_GAP: begin
        if (to_exp) begin
          nxt     = ST_IDLE;
          set_err = 1'b1;
        end else if (t_exp) begin
          nxt    = ST_READ;
          t_load = 1'b1;
          t_val  = READ_LD;
        end
      end
      ST_READ: if (t_exp) begin
        if (dq_in[MSB] == last_msb) begin
          nxt      = ST_IDLE;
          set_done = 1'b1;
        end else if (to_exp) begin
          nxt     = ST_IDLE;
          set_err = 1'b1;
        end else begin
          nxt    = ST_GAP;
          t_load = 1'b1;
          t_val  = gap_ld;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
      wdata     <= '0;
      last_addr <= '0;
      last_msb  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= set_done;
      err_q  <= set_err;
      if (cnt_load)  remaining <= cmd_count;
      else if (a_step) remaining <= remaining - PAGE_BITS'(1);
      if (cap_data)  wdata <= dat_byte;
      if (save_last) begin
        last_addr <= cur_addr;
        last_msb  <= wdata[MSB];
      end
    end
  end

  assign cmd_ready   = (state == ST_IDLE);
  assign dat_ready   = (state == ST_LOAD);
  assign done        = done_q;
  assign timeout_err = err_q;
  assign mem_cs_n    = !((state == ST_SETUP) || (state == ST_STROBE) ||
                         (state == ST_HOLD)  || (state == ST_READ));
  assign mem_we_n    = (state != ST_STROBE);
  assign mem_oe_n    = (state != ST_READ);
  assign dq_oe       = (state == ST_SETUP) || (state == ST_STROBE) ||
                       (state == ST_HOLD);
  assign dq_out      = wdata;
  assign mem_addr    = ((state == ST_READ) || (state == ST_GAP)) ? last_addr
                                                                 : cur_addr;
endmodule

// File: rtl/ewp_checker.sv
module ewp_checker #(
  parameter int ADDR_W    = 17,
  parameter int PULSE_CYC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              dat_ready,
  input logic              done,
  input logic              timeout_err,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dq_oe
);
  logic [15:0] wlow;

  always_ff @(posedge clk) begin
    if (!rst_n)         wlow <= '0;
    else if (!mem_we_n) wlow <= wlow + 16'd1;
    else                wlow <= '0;
  end

  a_r3_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && dq_oe));

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow == 16'(PULSE_CYC)));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  a_r4_drive_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (mem_oe_n && !mem_cs_n));

  a_r7_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n && !dq_oe));

  a_r2_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (mem_cs_n && !dat_ready));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (cmd_ready && !$past(timeout_err)));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err));
endmodule

bind eeprom_poll_writer ewp_checker #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)
) u_ewp_checker (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .dat_ready(dat_ready),
  .done(done), .timeout_err(timeout_err), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .dq_oe(dq_oe)
);

// File: tb/tb_eeprom_poll_writer.sv
`timescale 1ns/1ps
module tb_eeprom_poll_writer;
  localparam int AW = 17, DW = 8, PB = 6, GW = 16;
  localparam int SETUP = 3, PULSE = 5, HOLD = 2, RD = 4, TMO = 400;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [PB-1:0] cmd_count = '0;
  logic          dat_valid = 1'b0, dat_ready;
  logic [DW-1:0] dat_byte = '0;
  logic [GW-1:0] poll_gap = '0;
  logic          done, timeout_err;
  logic          mem_cs_n, mem_oe_n, mem_we_n, dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] dq_out;
  logic [DW-1:0] dq_in = '0;

  eeprom_poll_writer #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .GAP_W(GW), .SETUP_CYC(SETUP),
    .PULSE_CYC(PULSE), .HOLD_CYC(HOLD), .READ_CYC(RD), .TIMEOUT_CYC(TMO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_byte(dat_byte), .poll_gap(poll_gap),
    .done(done), .timeout_err(timeout_err), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  typedef struct { logic [AW-1:0] a; logic [7:0] d; } wr_t;
  typedef struct { bit err; int busy; int gap; } res_t;
  wr_t  exp_wr[$];
  res_t exp_res[$];

  int n_checks = 0, n_fail = 0;
  longint cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act,
                       input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // device model and monitors state
  logic [7:0] mem [int];
  logic [7:0] dlast = '0;
  int  busy_cfg = 0, busy_left = 0, cur_gap = 0;
  bit  stuck = 0;
  logic [AW-1:0] exp_last_addr = '0;
  bit  p_we = 1, p_oe = 1, p_cs = 1, wseen = 0;
  int  wlow = 0, cs_low_run = 0, cs_high_run = 0, since_rise = 0;
  longint last_rise = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int gmin;
      wr_t e;
      res_t r;
      gmin = (cur_gap < 1) ? 1 : cur_gap;
      // write strobe fall
      if (!mem_we_n && p_we) begin
        check(cs_low_run == SETUP, "R3 setup run before strobe", cs_low_run, SETUP);
        wlow = 0;
      end
      if (!mem_we_n) wlow++;
      // write strobe rise: scoreboard pop
      if (mem_we_n && !p_we) begin
        check(wlow == PULSE, "R3 strobe width", wlow, PULSE);
        if (exp_wr.size() == 0) begin
          check(0, "R2 unexpected write", mem_addr, 0);
        end else begin
          e = exp_wr.pop_front();
          check(mem_addr == e.a, "R5 write address", mem_addr, e.a);
          check(dq_out == e.d, "R3 write data", dq_out, e.d);
        end
        mem[int'(mem_addr)] = dq_out;
        dlast = dq_out;
        busy_left = busy_cfg;
        last_rise = cyc;
        since_rise = 1;
        wseen = 1;
      end else if (!mem_cs_n && wseen) begin
        since_rise++;
      end
      // select release after a write
      if (mem_cs_n && !p_cs && wseen) begin
        check(since_rise == HOLD, "R3 hold after strobe", since_rise, HOLD);
        wseen = 0;
      end
      // poll read start
      if (!mem_oe_n && p_oe) begin
        check(mem_addr == exp_last_addr, "R7 poll address", mem_addr, exp_last_addr);
        check(cs_high_run >= gmin, "R7 gap before poll", cs_high_run, gmin);
        check(!dq_oe, "R4 pad released in read", dq_oe, 0);
      end
      if (dq_oe) check(mem_oe_n && !mem_cs_n, "R4 drive only when selected", mem_oe_n, 1);
      // results
      if (done || timeout_err) begin
        check(!(done && timeout_err), "R10 done and error together", 1, 0);
        if (exp_res.size() == 0) begin
          check(0, "R8 unexpected result", done, 0);
        end else begin
          r = exp_res.pop_front();
          if (done) begin
            check(!r.err, "R8 done where timeout expected", 1, 0);
            check(cyc - last_rise >= r.busy, "R8 done while still busy",
                  cyc - last_rise, r.busy);
            check(cyc - last_rise <= r.busy + gmin + 2*RD + HOLD + 6,
                  "R8 done too late", cyc - last_rise, r.busy + gmin + 2*RD + HOLD + 6);
          end else begin
            check(r.err, "R9 timeout where done expected", 1, 0);
            check(cyc - last_rise >= TMO, "R9 timeout early", cyc - last_rise, TMO);
            check(cyc - last_rise <= TMO + HOLD + gmin + 2*RD + 6, "R9 timeout late",
                  cyc - last_rise, TMO + HOLD + gmin + 2*RD + 6);
          end
          check(cmd_ready, "R9 back to idle with result", cmd_ready, 1);
        end
      end
      // device busy and read data
      if (busy_left > 0 && !stuck) busy_left--;
      if (!mem_cs_n && !mem_oe_n) begin
        if (busy_left > 0) dq_in = {~dlast[7], dlast[6:0]};
        else if (mem.exists(int'(mem_addr))) dq_in = mem[int'(mem_addr)];
        else dq_in = 8'h00;
      end else begin
        dq_in = 8'h00;
      end
      cs_low_run  = mem_cs_n ? 0 : cs_low_run + 1;
      cs_high_run = mem_cs_n ? cs_high_run + 1 : 0;
      p_we = mem_we_n; p_oe = mem_oe_n; p_cs = mem_cs_n;
    end
  end

  task automatic run_op(input logic [AW-1:0] base, input int n, input logic [7:0] seed,
                        input int busy, input int gap, input bit stk, input bit eerr,
                        input bit stall);
    logic [7:0] bytes [64];
    wr_t w;
    busy_cfg = busy; stuck = stk; cur_gap = gap; poll_gap = GW'(gap);
    for (int k = 0; k < n; k++) begin
      bytes[k] = seed ^ 8'(k * 37);
      w.a = {base[AW-1:PB], PB'(int'(base[PB-1:0]) + k)};
      w.d = bytes[k];
      exp_wr.push_back(w);
      exp_last_addr = w.a;
    end
    exp_res.push_back('{eerr, busy, gap});
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = base; cmd_count = PB'(n - 1);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!cmd_ready, "R2 ready low after accept", cmd_ready, 0);
    for (int k = 0; k < n; k++) begin
      if (stall) repeat (k % 3) @(negedge clk);
      dat_valid = 1'b1; dat_byte = bytes[k];
      while (!dat_ready) @(negedge clk);
      @(negedge clk);
      dat_valid = 1'b0;
    end
    while (exp_res.size() != 0) @(negedge clk);
    check(exp_wr.size() == 0, "R6 byte count", exp_wr.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes idle in reset", mem_cs_n, 1);
    check(!dq_oe && !dat_ready, "R1 pad and data idle in reset", dq_oe, 0);
    check(!done && !timeout_err, "R1 no result in reset", done, 0);
    check(cmd_ready, "R1 ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && mem_cs_n, "R1 idle after reset", cmd_ready, 1);

    // R8 single byte, bit 7 low, device busy for a while
    run_op(17'h01234, 1, 8'h5A, 50, 8, 0, 0, 0);
    // R8 single byte, bit 7 high, no busy time, zero gap
    run_op(17'h1FFC0, 1, 8'hA5, 0, 0, 0, 0, 0);
    // R5 page wraps inside the page, with stalled data stream (R2)
    run_op(17'h0ABFC, 8, 8'h3C, 120, 5, 0, 0, 1);
    // R6 full page
    run_op(17'h10000, 64, 8'hC3, 30, 3, 0, 0, 0);

    // R2 data stream ignored while idle
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      dat_valid = 1'b1; dat_byte = 8'hFF;
      check(!dat_ready && mem_cs_n && mem_we_n, "R2 data ignored when idle",
            dat_ready, 0);
    end
    @(negedge clk);
    dat_valid = 1'b0;

    // R9 device never finishes
    run_op(17'h00200, 2, 8'h81, 1000000, 10, 1, 1, 0);
    // recovery after timeout
    run_op(17'h00300, 3, 8'h11, 25, 2, 0, 0, 0);

    repeat (5) @(negedge clk);
    check(exp_wr.size() == 0 && exp_res.size() == 0, "R2 scoreboard drained",
          exp_wr.size() + exp_res.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule